// File: doc/BRIEF.md
# Seven-Pin Shared I/O Port

This block is a seven-bit general-purpose I/O port. Each pin is either driven from a port output latch under a per-pin direction bit, or handed to an on-chip peripheral. Software reaches the latch and the direction bits over a small register bus: one address for the data register and one for the direction register. The block does not contain the serial interface or the timers. They appear only as enable and mode inputs, plus a per-pin drive enable and drive value that the block forwards to the pin when the peripheral owns it.

Pin 0 is the serial slave-select input. Pins 1, 2 and 3 are the serial data-in, data-out and clock lines. Pins 4 and 5 are timer channels 0 and 1. Pin 6 is always plain I/O. Pin inputs pass through a two-flop synchronizer. The synchronized values feed the register read path and are also passed on to the peripherals. A data-register read returns the latch or the synchronized pin, depending only on the direction bit, whoever owns the pin.

Top module: `pinmux_port`

## Requirements
- R1: When a pin is not owned by a peripheral, its output enable equals its direction bit (1 = drive, 0 = input), and its output value equals its latch bit.
- R2: After reset, all direction bits and latch bits are 0, so every output enable is 0.
- R3: The direction register is at address 0x07. Its bits 6..0 are read/write and bit 7 always reads 0, even after a write of 1 to it. Other addresses except 0x03 read as 0 and store nothing.
- R4: The data register is at address 0x03. For each bit i, a read returns latch bit i when direction bit i is 1, and synchronized pin i when it is 0. Bit 7 reads 0. This holds while a peripheral owns the pin.
- R5: While the serial enable is 1, pins 1 to 3 take their output enable and output value from the peripheral drive inputs, and the direction register has no effect on them. While it is 0, they follow R1.
- R6: Pin 0 follows R1 when the serial enable is 0 or serial master mode is 1. Otherwise it is owned as an input: output enable 0 and output value 0.
- R7: Timer pin 4 (mode bits ch0) and timer pin 5 (mode bits ch1) follow R1 when both of their two mode bits are 0. Any other mode value makes the pin take the peripheral drive inputs.
- R8: A data-register write updates the latch whatever the direction bits are. After the latch is written first and the direction bit is then set, the pin's output value is already the latched value in the cycle the output enable rises.
- R9: A pin input change becomes visible on the read path and on the synchronized outputs after exactly two rising clock edges.
- R10: Pin 6 is never owned by a peripheral and always follows R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Register address, used for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| spi_en | input | 1 | Serial interface enable |
| spi_master | input | 1 | Serial interface is master |
| tch0_mode | input | 2 | Timer channel 0 mode bits, 00 = pin released |
| tch1_mode | input | 2 | Timer channel 1 mode bits, 00 = pin released |
| per_oe | input | 7 | Peripheral output enable for each pin |
| per_out | input | 7 | Peripheral output value for each pin |
| pin_in | input | 7 | Pin input levels (asynchronous) |
| pin_oe | output | 7 | Pin output enable |
| pin_out | output | 7 | Pin output value |
| pin_sync | output | 7 | Synchronized pin levels passed to peripherals |

## Verification
A peripheral can give up a pin in the same cycle that a direction-register write lands. The bench lowers the serial enable and strobes a direction write on the same clock edge. It checks that the pins fall back at once to the old direction bits, and then show the new bits after that edge. A pin input can also change in the same cycle that a data-register write lands. The bench checks that the read follows the two-edge synchronizer while the direction bit is 0, and switches to the new latch value once the bit is set.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  // Pin roles; the peripherals decode these positions.
  localparam int PIN_SS   = 0;
  localparam int PIN_SDI  = 1;
  localparam int PIN_SDO  = 2;
  localparam int PIN_SCK  = 3;
  localparam int PIN_TCH0 = 4;
  localparam int PIN_TCH1 = 5;

  typedef enum logic [1:0] {
    OWN_PORT     = 2'd0,
    OWN_PERIPH   = 2'd1,
    OWN_PERIPH_IN = 2'd2
  } own_e;

  typedef struct packed {
    logic       spi_en;
    logic       spi_master;
    logic [1:0] tch0_mode;
    logic [1:0] tch1_mode;
  } mux_ctl_t;

  function automatic logic tch_claims(input logic [1:0] mode);
    return mode != 2'b00;
  endfunction
endpackage

// File: rtl/pmx_rst_sync.sv
module pmx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pmx_sync.sv
module pmx_sync #(
  parameter int NPIN   = 7,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_sync
);
  logic [NPIN-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [NPIN-1:0] chain_d;
    if (s == 0) begin : g_first
      assign chain_d = pin_in;
    end else begin : g_next
      assign chain_d = chain_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_d;
    end
  end

  assign pin_sync = chain_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age_q <= 2'd0;
      else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end
    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2) |-> (pin_sync == $past(pin_in, 2))) // R9
      else $error("sync latency");
  end
endmodule

// File: rtl/pmx_regs.sv
module pmx_regs #(
  parameter int          NPIN      = 7,
  parameter int          REG_W     = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  DATA_ADDR = 8'h03,
  parameter logic [7:0]  DIR_ADDR  = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [NPIN-1:0]   pin_sync,
  output logic [NPIN-1:0]   latch_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [REG_W-1:0]  rdata
);
  localparam int PAD_W = REG_W - NPIN;

  logic            hit_data, hit_dir;
  logic            latch_en, dir_en;
  logic [NPIN-1:0] latch_d, dir_d;
  logic [NPIN-1:0] data_view;
  logic            unused_hi;

  assign hit_data = (addr == ADDR_W'(DATA_ADDR));
  assign hit_dir  = (addr == ADDR_W'(DIR_ADDR));
  assign unused_hi = &{1'b0, wdata[REG_W-1:NPIN]};

  // next state
  always_comb begin
    latch_en = we && hit_data;
    dir_en   = we && hit_dir;
    latch_d  = wdata[NPIN-1:0];
    dir_d    = wdata[NPIN-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  // read path: direction bit alone picks latch or pin
  for (genvar i = 0; i < NPIN; i++) begin : g_view
    assign data_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
  end

  always_comb begin
    if (hit_data)     rdata = {{PAD_W{1'b0}}, data_view};
    else if (hit_dir) rdata = {{PAD_W{1'b0}}, dir_q};
    else              rdata = '0;
  end

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit_data) |=> (latch_q == $past(wdata[NPIN-1:0]))) // R8
    else $error("latch write lost");
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit_dir) |=> (dir_q == $past(wdata[NPIN-1:0]))) // R1
    else $error("dir write lost");
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit_dir) |=> $stable(dir_q)) // R3
    else $error("dir changed without write");
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[REG_W-1] == 1'b0) // R3
    else $error("top bit read nonzero");
endmodule

// File: rtl/pmx_owner.sv
module pmx_owner #(
  parameter int NPIN = 7
) (
  input  pmx_pkg::mux_ctl_t ctl,
  output pmx_pkg::own_e     pin_own [NPIN]
);
  import pmx_pkg::*;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    if (i == PIN_SS) begin : g_ss
      assign pin_own[i] = (ctl.spi_en && !ctl.spi_master) ? OWN_PERIPH_IN : OWN_PORT;
    end else if (i >= PIN_SDI && i <= PIN_SCK) begin : g_spi
      assign pin_own[i] = ctl.spi_en ? OWN_PERIPH : OWN_PORT;
    end else if (i == PIN_TCH0) begin : g_t0
      assign pin_own[i] = tch_claims(ctl.tch0_mode) ? OWN_PERIPH : OWN_PORT;
    end else if (i == PIN_TCH1) begin : g_t1
      assign pin_own[i] = tch_claims(ctl.tch1_mode) ? OWN_PERIPH : OWN_PORT;
    end else begin : g_plain
      assign pin_own[i] = OWN_PORT;
    end
  end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port #(
  parameter int          NPIN      = 7,
  parameter int          REG_W     = 8,
  parameter int          ADDR_W    = 8,
  parameter int          SYNC_STG  = 2,
  parameter logic [7:0]  DATA_ADDR = 8'h03,
  parameter logic [7:0]  DIR_ADDR  = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic [1:0]        tch0_mode,
  input  logic [1:0]        tch1_mode,
  input  logic [NPIN-1:0]   per_oe,
  input  logic [NPIN-1:0]   per_out,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_sync
);
  import pmx_pkg::*;

  logic            rst_sync_n;
  logic [NPIN-1:0] latch_q, dir_q;
  mux_ctl_t        ctl;
  own_e            pin_own [NPIN];

  assign ctl = '{spi_en: spi_en, spi_master: spi_master,
                 tch0_mode: tch0_mode, tch1_mode: tch1_mode};

  pmx_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pmx_sync #(.NPIN(NPIN), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .pin_in(pin_in), .pin_sync(pin_sync)
  );

  pmx_regs #(.NPIN(NPIN), .REG_W(REG_W), .ADDR_W(ADDR_W),
             .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .pin_sync(pin_sync), .latch_q(latch_q),
    .dir_q(dir_q), .rdata(bus_rdata)
  );

  pmx_owner #(.NPIN(NPIN)) u_owner (
    .ctl(ctl), .pin_own(pin_own)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_drive
    logic oe_i, out_i;
    always_comb begin
      unique case (pin_own[i])
        OWN_PERIPH:    begin oe_i = per_oe[i]; out_i = per_out[i]; end
        OWN_PERIPH_IN: begin oe_i = 1'b0;      out_i = 1'b0;       end
        default:       begin oe_i = dir_q[i];  out_i = latch_q[i]; end
      endcase
    end
    assign pin_oe[i]  = oe_i;
    assign pin_out[i] = out_i;
  end

  AST_SS_OWNED_INPUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (spi_en && !spi_master) |-> (!pin_oe[PIN_SS] && !pin_out[PIN_SS])) // R6
    else $error("slave select driven while owned");
  AST_SPI_IGNORES_DIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    spi_en |-> (pin_oe[PIN_SCK:PIN_SDI] == per_oe[PIN_SCK:PIN_SDI])) // R5
    else $error("serial pins follow direction");
  AST_TCH0_RELEASED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tch0_mode == 2'b00) |-> (pin_oe[PIN_TCH0] == dir_q[PIN_TCH0])) // R7
    else $error("timer pin held");
  AST_PLAIN_PIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pin_oe[NPIN-1] == dir_q[NPIN-1]) && (pin_out[NPIN-1] == latch_q[NPIN-1])) // R10
    else $error("plain pin taken");
  AST_NO_GLITCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(dir_q[NPIN-1]) && $stable(latch_q[NPIN-1])) |-> (pin_out[NPIN-1] == latch_q[NPIN-1])) // R8
    else $error("glitch on enable");
endmodule

// File: tb/pinmux_port_bench.sv
module pinmux_port_bench;
  localparam int NPIN = 7;
  localparam logic [7:0] A_DATA = 8'h03;
  localparam logic [7:0] A_DIR  = 8'h07;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic spi_en = 1'b0, spi_master = 1'b0;
  logic [1:0] tch0_mode = 2'b00, tch1_mode = 2'b00;
  logic [NPIN-1:0] per_oe = '0, per_out = '0, pin_in = '0;
  logic [NPIN-1:0] pin_oe, pin_out, pin_sync;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  pinmux_port u_pinmux_port (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_en(spi_en),
    .spi_master(spi_master), .tch0_mode(tch0_mode), .tch1_mode(tch1_mode),
    .per_oe(per_oe), .per_out(per_out), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .pin_sync(pin_sync)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R2 oe", {1'b0, pin_oe}, 8'h00);
    rd(A_DIR, v);  chk("R2 dir", v, 8'h00);
    wr(A_DIR, 8'h7F);
    rd(A_DATA, v); chk("R2 latch", v, 8'h00);
    wr(A_DIR, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk); pin_in = 7'h5A;
    @(negedge clk);
    rd(A_DATA, v); chk("R9 one edge", v, 8'h00);
    @(negedge clk);
    rd(A_DATA, v); chk("R9 two edges", v, 8'h5A);
    chk("R9 sync out", {1'b0, pin_sync}, 8'h5A);
    pin_in = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_dir;
    logic [7:0] v;
    wr(A_DATA, 8'h2B);
    wr(A_DIR, 8'hFF);
    chk("R1 oe all", {1'b0, pin_oe}, 8'h7F);
    chk("R1 out", {1'b0, pin_out}, 8'h2B);
    rd(A_DIR, v); chk("R3 top bit", v, 8'h7F);
    wr(A_DIR, 8'h80);
    rd(A_DIR, v); chk("R3 bit7 ignored", v, 8'h00);
    chk("R1 oe off", {1'b0, pin_oe}, 8'h00);
    wr(8'h05, 8'hFF);
    rd(8'h05, v); chk("R3 other addr", v, 8'h00);
    rd(A_DIR, v); chk("R3 other no store", v, 8'h00);
  endtask

  task automatic t_readmux;
    logic [7:0] v;
    wr(A_DATA, 8'h55);
    wr(A_DIR, 8'h0F);
    pin_in = 7'h3A;
    repeat (3) @(negedge clk);
    rd(A_DATA, v); chk("R4 mixed read", v, 8'h35);
  endtask

  task automatic t_spi;
    logic [7:0] v;
    wr(A_DATA, 8'h00);
    wr(A_DIR, 8'h7F);
    spi_en = 1'b1; spi_master = 1'b0;
    per_oe = 7'h0A; per_out = 7'h0F;
    #1;
    chk("R5/R6 slave oe", {1'b0, pin_oe}, 8'h7A);
    chk("R5/R6 slave out", {1'b0, pin_out}, 8'h0E);
    rd(A_DATA, v); chk("R4 owned reads latch", v, 8'h00);
    spi_master = 1'b1;
    #1;
    chk("R6 master frees ss", {1'b0, pin_oe}, 8'h7B);
    spi_en = 1'b0;
    #1;
    chk("R5 disabled", {1'b0, pin_oe}, 8'h7F);
    spi_master = 1'b0;
  endtask

  task automatic t_timer;
    per_oe = 7'h00; per_out = 7'h7F;
    tch0_mode = 2'b01;
    #1; chk("R7 ch0 owned", {1'b0, pin_oe}, 8'h6F);
    tch1_mode = 2'b10;
    #1; chk("R7 ch1 owned", {1'b0, pin_oe}, 8'h4F);
    chk("R7 out", {1'b0, pin_out}, 8'h30);
    tch0_mode = 2'b00;
    #1; chk("R7 ch0 free", {1'b0, pin_oe}, 8'h5F);
    tch0_mode = 2'b11; tch1_mode = 2'b11; spi_en = 1'b1;
    wr(A_DIR, 8'h40);
    chk("R10 plain pin", {1'b0, pin_oe}, 8'h40);
    tch0_mode = 2'b00; tch1_mode = 2'b00; spi_en = 1'b0; per_out = '0;
    wr(A_DIR, 8'h00);
  endtask

  task automatic t_preload;
    wr(A_DATA, 8'h04);
    chk("R8 latch no drive", {1'b0, pin_oe}, 8'h00);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = A_DIR; bus_wdata = 8'h04;
    @(posedge clk); #0.5;
    chk("R8 oe rose", {7'b0, pin_oe[2]}, 8'h01);
    chk("R8 no glitch", {7'b0, pin_out[2]}, 8'h01);
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic t_collide;
    logic [7:0] v;
    wr(A_DIR, 8'h00);
    spi_en = 1'b1; per_oe = 7'h0E;
    #1; chk("R5 owned before", {1'b0, pin_oe}, 8'h0E);
    @(negedge clk);
    spi_en = 1'b0; bus_we = 1'b1; bus_addr = A_DIR; bus_wdata = 8'h0E;
    #1; chk("R5 release old dir", {1'b0, pin_oe}, 8'h00);
    @(negedge clk); bus_we = 1'b0;
    chk("R1 new dir", {1'b0, pin_oe}, 8'h0E);
    wr(A_DIR, 8'h00);
    @(negedge clk);
    pin_in = 7'h11; bus_we = 1'b1; bus_addr = A_DATA; bus_wdata = 8'h66;
    @(negedge clk); bus_we = 1'b0;
    @(negedge clk);
    rd(A_DATA, v); chk("R9 pin during write", v, 8'h11);
    wr(A_DIR, 8'h7F);
    rd(A_DATA, v); chk("R8 latch kept", v, 8'h66);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sync();
    t_dir();
    t_readmux();
    t_spi();
    t_timer();
    t_preload();
    t_collide();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule